// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA with Global Stop Flags

This block copies a run of data units from one memory region to another on behalf of software. Software loads a source address, a destination address, a unit count and a unit size (1, 2 or 4 bytes). It then sets a channel enable bit and a global master enable bit. For each unit the engine issues one read on a simple request/grant bus, then one write of the same data. Both addresses then advance by the unit size and the count drops by one. When the count reaches zero a done flag is set and an optional one-cycle interrupt fires.

Two global conditions stop the channel early. One is a non-maskable event input, which raises a sticky event flag. The other is an address error, raised when an address is not aligned to the unit size. Clearing the master enable also stops the channel. In every case a unit already on the bus runs to the end of its write, and the engine then starts no further unit. The channel keeps the remaining count and the next source and destination addresses, so software can inspect the stopped transfer and resume it.

Register map used by every requirement (word select `reg_sel`): 0 source address, 1 destination address, 2 remaining count, 3 channel control (bit0 enable, bit1 done, bit2 interrupt enable, bits5:4 size code), 4 global (bit0 master enable, bit1 event flag, bit2 address-error flag).

Top module: `dma_channel`

## Requirements
- R1: A unit starts only while global bit0 and control bit0 are both 1 and no flag blocks it. Either enable may be set first.
- R2: A one-cycle pulse on `nmi_in` sets global bit1 even when the channel is idle. While bit1 is 1, no new unit starts.
- R3: If global bit1 is already set when the channel is enabled, the count, source and destination registers keep their programmed values.
- R4: If `nmi_in` fires during a transfer, the unit on the bus completes and the channel stops with control bit0=1 and bit1=0. The count register then holds the units left, and the address registers hold the next addresses.
- R5: Each unit reads at the source address and writes that data to the destination address. Both addresses then advance by 1, 2 or 4 bytes (size code 0, 1, 2; code 3 also means 4), and the count drops by 1.
- R6: A source or destination address misaligned for the size code sets global bit2 with no bus request. The address and count registers are left unchanged.
- R7: Writing global bit0 to 0 while a unit is on the bus lets that unit's write finish. No unit follows it.
- R8: When the count reaches 0, control bit1 becomes 1 and the channel stops.
- R9: While control bit0 is 1, writes to registers 0–2 are ignored. A control write then changes only bit0 and bit1, and the interrupt enable and size fields keep their values.
- R10: Global bits 1 and 2 clear only when a 0 is written to them after a read that returned them as 1. Writing 1 to them has no effect.
- R11: Writing 0 to control bit1 clears it.
- R12: `irq` pulses high for exactly one cycle when control bit1 is set, and only if control bit2 is 1.
- R13: After reset every register reads 0, and `bus_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (arms flag clearing) |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| nmi_in | input | 1 | Non-maskable stop event |
| bus_req | output | 1 | Bus request, held until grant |
| bus_we | output | 1 | 1 = write phase, 0 = read phase |
| bus_addr | output | 32 | Bus byte address |
| bus_size | output | 2 | Unit size code of the access |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with grant |
| bus_gnt | input | 1 | Grant; completes the current access |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest state to reach from the ports is a stop event that lands while a unit is half done, after its read and before its write. In that state, the remaining count and the next addresses must still describe exactly the units not yet moved. The bench reaches it by watching the bus. It fires `nmi_in`, or clears the master enable, right after it sees a read grant. It then checks that one more write appears, and that the count and addresses match the writes it logged. After the flag is cleared, the bench resumes the transfer and confirms that the address sequence continues without a gap.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int REG_W = 32;
    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_SRC  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DST  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_CNT  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd3;
    localparam logic [SEL_W-1:0] SEL_GLOB = 3'd4;

    localparam int CTRL_EN    = 0;
    localparam int CTRL_DONE  = 1;
    localparam int CTRL_IE    = 2;
    localparam int CTRL_SZ_LO = 4;

    localparam int GLOB_ME  = 0;
    localparam int GLOB_NMI = 1;
    localparam int GLOB_AE  = 2;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_READ,
        ENG_WRITE
    } eng_state_e;

    typedef struct packed {
        logic master_en;
        logic nmi_flag;
        logic nmi_armed;
        logic addr_err;
        logic ae_armed;
    } glob_t;

    typedef struct packed {
        logic       enable;
        logic       done;
        logic       irq_en;
        logic [1:0] size;
    } ctrl_t;

    function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic misaligned(input logic [1:0] lsb, input logic [1:0] sz);
        case (sz)
            2'd0:    return 1'b0;
            2'd1:    return lsb[0];
            default: return (lsb != 2'd0);
        endcase
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              nmi_in,
    input  logic              unit_done,
    input  logic              addr_fault,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [1:0]        size_o,
    output logic              run_ok_o,
    output logic              irq_o
);

    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [CNT_W-1:0]  cnt_q;
    ctrl_t             ctrl_q;
    glob_t             glob_q;
    logic              irq_q;

    logic [ADDR_W-1:0] step;
    logic              wr_src, wr_dst, wr_cnt, wr_ctrl, wr_glob, rd_glob;
    logic              chan_open;
    logic              last_unit;

    assign step      = ADDR_W'(unit_bytes(ctrl_q.size));
    assign chan_open = !ctrl_q.enable;
    assign wr_src    = reg_we && (reg_sel == SEL_SRC);
    assign wr_dst    = reg_we && (reg_sel == SEL_DST);
    assign wr_cnt    = reg_we && (reg_sel == SEL_CNT);
    assign wr_ctrl   = reg_we && (reg_sel == SEL_CTRL);
    assign wr_glob   = reg_we && (reg_sel == SEL_GLOB);
    assign rd_glob   = reg_re && (reg_sel == SEL_GLOB);
    assign last_unit = unit_done && (cnt_q == CNT_W'(1));

    // channel address and count registers
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (unit_done) begin
            src_q <= src_q + step;
            dst_q <= dst_q + step;
            if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
        end else if (chan_open) begin
            if (wr_src) src_q <= reg_wdata[ADDR_W-1:0];
            if (wr_dst) dst_q <= reg_wdata[ADDR_W-1:0];
            if (wr_cnt) cnt_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // channel control
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= last_unit && ctrl_q.irq_en;
            if (wr_ctrl) begin
                ctrl_q.enable <= reg_wdata[CTRL_EN];
                if (chan_open) begin
                    ctrl_q.irq_en <= reg_wdata[CTRL_IE];
                    ctrl_q.size   <= reg_wdata[CTRL_SZ_LO +: 2];
                end
            end
            if (last_unit)
                ctrl_q.done <= 1'b1;
            else if (wr_ctrl && !reg_wdata[CTRL_DONE])
                ctrl_q.done <= 1'b0;
        end
    end

    // global operation register
    always_ff @(posedge clk) begin
        if (rst) begin
            glob_q <= '0;
        end else begin
            if (wr_glob) glob_q.master_en <= reg_wdata[GLOB_ME];

            if (nmi_in) begin
                glob_q.nmi_flag <= 1'b1;
            end else if (wr_glob && glob_q.nmi_armed && !reg_wdata[GLOB_NMI]) begin
                glob_q.nmi_flag  <= 1'b0;
                glob_q.nmi_armed <= 1'b0;
            end else if (rd_glob && glob_q.nmi_flag) begin
                glob_q.nmi_armed <= 1'b1;
            end

            if (addr_fault) begin
                glob_q.addr_err <= 1'b1;
            end else if (wr_glob && glob_q.ae_armed && !reg_wdata[GLOB_AE]) begin
                glob_q.addr_err <= 1'b0;
                glob_q.ae_armed <= 1'b0;
            end else if (rd_glob && glob_q.addr_err) begin
                glob_q.ae_armed <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_SRC: reg_rdata = REG_W'(src_q);
            SEL_DST: reg_rdata = REG_W'(dst_q);
            SEL_CNT: reg_rdata = REG_W'(cnt_q);
            SEL_CTRL: begin
                reg_rdata[CTRL_EN]           = ctrl_q.enable;
                reg_rdata[CTRL_DONE]         = ctrl_q.done;
                reg_rdata[CTRL_IE]           = ctrl_q.irq_en;
                reg_rdata[CTRL_SZ_LO +: 2]   = ctrl_q.size;
            end
            SEL_GLOB: begin
                reg_rdata[GLOB_ME]  = glob_q.master_en;
                reg_rdata[GLOB_NMI] = glob_q.nmi_flag;
                reg_rdata[GLOB_AE]  = glob_q.addr_err;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign src_o    = src_q;
    assign dst_o    = dst_q;
    assign size_o   = ctrl_q.size;
    assign irq_o    = irq_q;
    assign run_ok_o = glob_q.master_en && ctrl_q.enable && !ctrl_q.done &&
                      !glob_q.nmi_flag && !glob_q.addr_err && (cnt_q != '0);

    // R3
    cnt_hold_nmi_chk: assert property (@(posedge clk) disable iff (rst)
        (glob_q.nmi_flag && ctrl_q.enable && !unit_done) |=> $stable(cnt_q));

    // R8
    done_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        last_unit |=> (ctrl_q.done && (cnt_q == '0)));

    // R12
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    // R12
    irq_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ctrl_q.done);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_ok,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [1:0]        size,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_gnt,
    output logic              unit_done,
    output logic              addr_fault
);

    eng_state_e        state_q;
    logic [ADDR_W-1:0] src_l;
    logic [ADDR_W-1:0] dst_l;
    logic [1:0]        size_l;
    logic [DATA_W-1:0] data_l;
    logic              bad_align;

    assign bad_align  = misaligned(src[1:0], size) || misaligned(dst[1:0], size);
    assign addr_fault = (state_q == ENG_IDLE) && run_ok && bad_align;
    assign unit_done  = (state_q == ENG_WRITE) && bus_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            src_l   <= '0;
            dst_l   <= '0;
            size_l  <= '0;
            data_l  <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (run_ok && !bad_align) begin
                        src_l   <= src;
                        dst_l   <= dst;
                        size_l  <= size;
                        state_q <= ENG_READ;
                    end
                end
                ENG_READ: begin
                    if (bus_gnt) begin
                        data_l  <= bus_rdata;
                        state_q <= ENG_WRITE;
                    end
                end
                ENG_WRITE: begin
                    if (bus_gnt) state_q <= ENG_IDLE;
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign bus_req   = (state_q != ENG_IDLE);
    assign bus_we    = (state_q == ENG_WRITE);
    assign bus_addr  = (state_q == ENG_WRITE) ? dst_l : src_l;
    assign bus_size  = size_l;
    assign bus_wdata = data_l;

    // R1
    start_needs_enables_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(run_ok));

    // R7
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R7
    read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_gnt) |=> (bus_req && bus_we));

    // R6
    fault_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        addr_fault |=> !bus_req);

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              nmi_in,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_gnt,
    output logic              irq
);

    logic [ADDR_W-1:0] cur_src;
    logic [ADDR_W-1:0] cur_dst;
    logic [1:0]        cur_size;
    logic              run_ok;
    logic              unit_done;
    logic              addr_fault;

    dma_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .nmi_in     (nmi_in),
        .unit_done  (unit_done),
        .addr_fault (addr_fault),
        .src_o      (cur_src),
        .dst_o      (cur_dst),
        .size_o     (cur_size),
        .run_ok_o   (run_ok),
        .irq_o      (irq)
    );

    dma_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .run_ok     (run_ok),
        .src        (cur_src),
        .dst        (cur_dst),
        .size       (cur_size),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_gnt    (bus_gnt),
        .unit_done  (unit_done),
        .addr_fault (addr_fault)
    );

    // R2
    no_start_on_nmi_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_in && !bus_req) |=> ##1 !$rose(bus_req));

endmodule

// File: tb/dma_channel_test.sv
module dma_channel_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we, reg_re;
    logic [2:0]  reg_sel;
    logic [31:0] reg_wdata, reg_rdata;
    logic        nmi_in;
    logic        bus_req, bus_we, bus_gnt, irq;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;

    always #5 clk = ~clk;

    dma_channel uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_in(nmi_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_gnt(bus_gnt), .irq(irq)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0000_5A5A;
    endfunction

    always @(posedge clk) begin
        if (rst) bus_gnt <= 1'b0;
        else     bus_gnt <= bus_req && !bus_gnt;
    end
    assign bus_rdata = pat(bus_addr);

    // rows: source, destination, count, size code
    localparam logic [31:0] VEC [4][4] = '{
        '{32'h0000_0100, 32'h0000_0800, 32'd3, 32'd2},
        '{32'h0000_0201, 32'h0000_0301, 32'd5, 32'd0},
        '{32'h0000_0402, 32'h0000_0600, 32'd4, 32'd1},
        '{32'h0000_1000, 32'h0000_2000, 32'd1, 32'd3}
    };

    int          checks = 0;
    int          failures = 0;
    int          nwrites = 0;
    int          irqs = 0;
    logic [31:0] exp_src, exp_dst, rd_addr, step_b;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_sel = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_sel = a; #1; d = reg_rdata; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_writes(input int n);
        for (int i = 0; i < 3000 && nwrites < n; i++) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] c, input logic [1:0] sz);
        step_b  = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
        exp_src = s; exp_dst = d; nwrites = 0; irqs = 0;
        wr(3'd0, s); wr(3'd1, d); wr(3'd2, c);
    endtask

    task automatic stop_all();
        wr(3'd3, 32'h0); wr(3'd3, 32'h0); wr(3'd4, 32'h0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        logic [31:0] v;
        int n0;
        rst = 1'b1; reg_we = 0; reg_re = 0; reg_sel = 0; reg_wdata = 0; nmi_in = 0;
        exp_src = 0; exp_dst = 0; rd_addr = 0; step_b = 1;

        fork
            begin : watchdog
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog", "run did not finish", 32'd0, 32'd1);
                summary();
                $finish;
            end
            begin : monitor
                forever begin
                    @(negedge clk);
                    if (!rst && bus_req && bus_gnt) begin
                        if (!bus_we) begin
                            rd_addr = bus_addr;
                            chk(rd_addr == exp_src, "R5", "read address", rd_addr, exp_src);
                        end else begin
                            chk(bus_addr == exp_dst, "R5", "write address", bus_addr, exp_dst);
                            chk(bus_wdata == pat(rd_addr), "R5", "write data", bus_wdata, pat(rd_addr));
                            exp_src = exp_src + step_b;
                            exp_dst = exp_dst + step_b;
                            nwrites++;
                        end
                    end
                    if (!rst && irq) irqs++;
                end
            end
        join_none

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk(v == 0, "R13", "register after reset", v, 0);
        end
        chk(!bus_req && !irq, "R13", "bus_req/irq after reset", {30'd0, bus_req, irq}, 0);

        // table walk: enable channel first, then master enable
        for (int r = 0; r < 4; r++) begin
            logic [31:0] s, d, c, sz;
            s = VEC[r][0]; d = VEC[r][1]; c = VEC[r][2]; sz = VEC[r][3];
            setup(s, d, c, sz[1:0]);
            wr(3'd3, 32'h5 | (sz << 4));
            wr(3'd0, 32'hDEAD_BEEC);
            rd(3'd0, v);
            chk(v == s, "R9", "source write ignored while enabled", v, s);
            wr(3'd4, 32'h1);
            wait_writes(int'(c));
            idle(8);
            chk(nwrites == int'(c), "R5", "unit count", nwrites, c);
            rd(3'd0, v); chk(v == s + c * step_b, "R5", "final source", v, s + c * step_b);
            rd(3'd1, v); chk(v == d + c * step_b, "R5", "final destination", v, d + c * step_b);
            rd(3'd2, v); chk(v == 0, "R8", "count at end", v, 0);
            rd(3'd3, v); chk(v[1] == 1'b1, "R8", "done flag", v, 32'h2);
            chk(irqs == 1, "R12", "interrupt pulses", irqs, 1);
            wr(3'd3, 32'h0);
            rd(3'd3, v);
            chk(v == (32'h4 | (sz << 4)), "R11", "done cleared, fields kept (R9)", v, 32'h4 | (sz << 4));
            stop_all();
        end

        // R1: master first, then channel; no transfer before both
        setup(32'h0000_4000, 32'h0000_4800, 32'd2, 2'd2);
        wr(3'd4, 32'h1);
        idle(12);
        chk(nwrites == 0, "R1", "no unit with only master enable", nwrites, 0);
        wr(3'd3, 32'h20 | 32'h1);
        wait_writes(2); idle(6);
        chk(nwrites == 2, "R1", "units after both enables", nwrites, 2);
        chk(irqs == 0, "R12", "no pulse with interrupt enable 0", irqs, 0);
        stop_all();

        // R2 / R3 / R10: event flag set while idle
        setup(32'h0000_5000, 32'h0000_5800, 32'd3, 2'd2);
        nmi_in = 1'b1; @(negedge clk); nmi_in = 1'b0;
        wr(3'd4, 32'h0);
        rd(3'd4, v);
        chk(v == 32'h2, "R10", "flag kept without prior read", v, 32'h2);
        wr(3'd3, 32'h21);
        wr(3'd4, 32'h3);
        idle(12);
        chk(nwrites == 0, "R2", "no unit while event flag set", nwrites, 0);
        rd(3'd2, v); chk(v == 3, "R3", "count keeps programmed value", v, 3);
        rd(3'd0, v); chk(v == 32'h5000, "R3", "source unchanged", v, 32'h5000);
        wr(3'd4, 32'h1);
        rd(3'd4, v); chk(v == 32'h1, "R10", "flag cleared after read then write 0", v, 32'h1);
        wait_writes(3); idle(6);
        chk(nwrites == 3, "R2", "transfer after flag cleared", nwrites, 3);
        stop_all();

        // R4: event during a transfer, then resume
        setup(32'h0000_3000, 32'h0000_5000, 32'd8, 2'd1);
        wr(3'd3, 32'h11); wr(3'd4, 32'h1);
        wait_writes(2);
        nmi_in = 1'b1; @(negedge clk); nmi_in = 1'b0;
        idle(12);
        n0 = nwrites;
        chk(n0 >= 2 && n0 <= 3, "R4", "units before stop", n0, 3);
        rd(3'd2, v); chk(v == 32'(8 - n0), "R4", "remaining count", v, 32'(8 - n0));
        rd(3'd0, v); chk(v == 32'h3000 + 32'(2 * n0), "R4", "next source", v, 32'h3000 + 32'(2 * n0));
        rd(3'd1, v); chk(v == 32'h5000 + 32'(2 * n0), "R4", "next destination", v, 32'h5000 + 32'(2 * n0));
        rd(3'd3, v); chk(v[1:0] == 2'b01, "R4", "enable 1 done 0", v, 32'h1);
        rd(3'd4, v);
        wr(3'd4, 32'h1);
        wait_writes(8); idle(6);
        chk(nwrites == 8, "R4", "resumed transfer completes", nwrites, 8);
        stop_all();

        // R7: clear master enable right after a read grant
        setup(32'h0000_7000, 32'h0000_7400, 32'd6, 2'd2);
        wr(3'd3, 32'h21); wr(3'd4, 32'h1);
        for (int i = 0; i < 3000; i++) begin
            if (bus_req && !bus_we && bus_gnt && nwrites >= 1) break;
            @(negedge clk);
        end
        n0 = nwrites;
        wr(3'd4, 32'h0);
        idle(15);
        chk(nwrites == n0 + 1, "R7", "unit in flight finishes, none after", nwrites, n0 + 1);
        rd(3'd2, v); chk(v == 32'(6 - nwrites), "R7", "remaining count", v, 32'(6 - nwrites));
        stop_all();

        // R6: misaligned source for word units
        setup(32'h0000_0102, 32'h0000_0200, 32'd2, 2'd2);
        wr(3'd3, 32'h21); wr(3'd4, 32'h1);
        idle(10);
        chk(nwrites == 0, "R6", "no unit on misaligned address", nwrites, 0);
        rd(3'd4, v); chk(v == 32'h5, "R6", "address-error flag", v, 32'h5);
        rd(3'd0, v); chk(v == 32'h102, "R6", "source unchanged", v, 32'h102);
        rd(3'd2, v); chk(v == 2, "R6", "count unchanged", v, 2);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h4);
        rd(3'd4, v); chk(v == 32'h4, "R10", "writing 1 keeps flag", v, 32'h4);
        wr(3'd4, 32'h0);
        rd(3'd4, v); chk(v == 32'h0, "R10", "address-error flag cleared", v, 0);

        summary();
        $finish;
    end

endmodule